// File: doc/BRIEF.md
# Programmable Trigger Delay and Width Generator

The block turns one rising edge of a level-1 trigger strobe into four timed events. These are a sampling strobe that captures the sector-wise multiplicity inputs, two drift-chamber trigger pulses (one for the inner plane pair, one for the outer plane pair), and a stretched level-1 output pulse. All four timings are codes in one 32-bit control word that is written through a single write-enable and data port. The block is meant for a 200 MHz clock, so one cycle is 5 ns.

Each timing code is captured when a trigger is accepted. While any delay or width counter is still running, further triggers are dropped. A later write to the control word therefore shapes only the next accepted trigger.

Top module: `tdw_gen`

## Requirements
- R1: A write (`cfg_we_i` high at a clock edge) stores `cfg_wdata_i`. The stored word sets the timing of every trigger accepted after that edge. Field positions: sampling code in bits 3:0, outer-pair delay code in bits 16:12, inner-pair delay code in bits 21:17, width code in bits 31:28.
- R2: A trigger is accepted at the edge that first sees `trig_i` high after it was low. `samp_stb_o` is then high for exactly one cycle, asserted at accepted edge + 6 + sampling code (30 ns + code x 5 ns).
- R3: At the edge that raises `samp_stb_o`, `mult_o` takes the value `mult_i` had before that edge, and `mult_vld_o` is high in exactly the same cycle. At all other times `mult_o` holds its value.
- R4: `mdc_out_o` pulses for one cycle, asserted at accepted edge + 4 x outer code (20 ns steps). Code 0 asserts it at the accepting edge itself.
- R5: `mdc_in_o` pulses for one cycle, asserted at accepted edge + 4 x inner code.
- R6: `lvl1_o` rises at the accepting edge. It stays high for 21 + code cycles when the width code is below 7 (105 ns + code x 5 ns), and for code cycles when the code is 7 to 15.
- R7: A trigger held high produces exactly one set of outputs.
- R8: A rising edge on `trig_i` that arrives while any delay or width counter is running is ignored.
- R9: A write to the control word during a running sequence does not change that sequence.
- R10: After reset all outputs are low and the control word is zero. A trigger with no prior write therefore gives sampling at +6, both drift-chamber pulses at +0 and a 21-cycle level-1 pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 5 ns nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | 32 | Control word write data |
| trig_i | input | 1 | Level-1 trigger strobe |
| mult_i | input | 24 | Sector multiplicities, 6 sectors x 4 bits |
| samp_stb_o | output | 1 | Multiplicity sampling strobe |
| mult_o | output | 24 | Latched multiplicities |
| mult_vld_o | output | 1 | Latched multiplicities valid, one cycle |
| mdc_in_o | output | 1 | Inner plane pair trigger pulse |
| mdc_out_o | output | 1 | Outer plane pair trigger pulse |
| lvl1_o | output | 1 | Stretched level-1 output |

## Verification
The hardest case to reach is a second rising edge, or a control word write, that lands inside a running sequence. The inputs look legal, and only the timing of the outputs shows whether the sequence was disturbed. The stimulus sets a long outer-pair delay, drops and re-raises the trigger a few cycles after acceptance, and writes a different word mid-run. It then checks that every output still follows the word captured at acceptance and fires only once. A following trigger confirms that the new word has taken effect. The multiplicity input changes on every cycle, so a capture one edge early or one edge late shows up as a wrong value.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int SAMP_LSB = 0;
  localparam int SAMP_CW  = 4;
  localparam int OUT_LSB  = 12;
  localparam int IN_LSB   = 17;
  localparam int MDC_CW   = 5;
  localparam int WID_LSB  = 28;
  localparam int WID_CW   = 4;

  typedef struct packed {
    logic [SAMP_CW-1:0] samp;
    logic [MDC_CW-1:0]  mdc_out;
    logic [MDC_CW-1:0]  mdc_in;
    logic [WID_CW-1:0]  wid;
  } tdw_cfg_t;

  function automatic tdw_cfg_t tdw_decode(input logic [31:0] w);
    tdw_cfg_t c;
    c.samp    = w[SAMP_LSB +: SAMP_CW];
    c.mdc_out = w[OUT_LSB  +: MDC_CW];
    c.mdc_in  = w[IN_LSB   +: MDC_CW];
    c.wid     = w[WID_LSB  +: WID_CW];
    return c;
  endfunction
endpackage

// File: rtl/tdw_delay.sv
module tdw_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             fire_o,
  output logic             pulse_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  // fire is the edge at which the registered pulse rises
  assign fire_o = (start_i && dly_i == '0) || (act_q && cnt_q == CNT_W'(1));
  assign busy_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (start_i && dly_i != '0) begin
        act_q <= 1'b1;
        cnt_q <= dly_i;
      end else if (act_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
      end
    end
  end

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
  p_cnt_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0));
endmodule

// File: rtl/tdw_stretch.sv
module tdw_stretch #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (start_i) begin
      out_o <= 1'b1;
      cnt_q <= len_i - CNT_W'(1);
    end else if (out_o) begin
      if (cnt_q == '0) out_o <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_width_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |=> out_o);
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !out_o);
endmodule

// File: rtl/tdw_gen.sv
module tdw_gen
  import tdw_pkg::*;
#(
  parameter int SAMP_BASE = 6,
  parameter int MDC_STEP  = 4,
  parameter int WID_BASE  = 21,
  parameter int WID_KNEE  = 7,
  parameter int NSECT     = 6,
  parameter int SECT_W    = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [31:0]             cfg_wdata_i,
  input  logic                    trig_i,
  input  logic [NSECT*SECT_W-1:0] mult_i,
  output logic                    samp_stb_o,
  output logic [NSECT*SECT_W-1:0] mult_o,
  output logic                    mult_vld_o,
  output logic                    mdc_in_o,
  output logic                    mdc_out_o,
  output logic                    lvl1_o
);
  localparam int MULT_W = NSECT * SECT_W;
  localparam int SD_W   = $clog2(SAMP_BASE + (1 << SAMP_CW)) + 1;
  localparam int MD_W   = $clog2(MDC_STEP * (1 << MDC_CW)) + 1;
  localparam int WD_W   = $clog2(WID_BASE + (1 << WID_CW)) + 1;

  logic [31:0] cfg_q;
  logic        trig_q;
  logic        rise;
  logic        busy;
  logic        samp_fire, samp_busy;
  logic [1:0]  mdc_pulse, mdc_busy, mdc_fire;
  tdw_cfg_t    cfg;
  logic [MD_W-1:0] mdc_dly [2];
  logic [WD_W-1:0] wid_len;

  assign cfg  = tdw_decode(cfg_q);
  assign busy = samp_busy | (|mdc_busy) | lvl1_o;
  assign rise = trig_i & ~trig_q & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end
  end

  tdw_delay #(.CNT_W(SD_W)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rise),
    .dly_i   (SD_W'(SAMP_BASE) + SD_W'(cfg.samp)),
    .fire_o  (samp_fire),
    .pulse_o (samp_stb_o),
    .busy_o  (samp_busy)
  );

  assign mdc_dly[0] = MD_W'(MDC_STEP) * MD_W'(cfg.mdc_in);
  assign mdc_dly[1] = MD_W'(MDC_STEP) * MD_W'(cfg.mdc_out);

  for (genvar g = 0; g < 2; g++) begin : g_mdc
    tdw_delay #(.CNT_W(MD_W)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (rise),
      .dly_i   (mdc_dly[g]),
      .fire_o  (mdc_fire[g]),
      .pulse_o (mdc_pulse[g]),
      .busy_o  (mdc_busy[g])
    );
  end
  assign mdc_in_o  = mdc_pulse[0];
  assign mdc_out_o = mdc_pulse[1];

  // piecewise width: fixed base below the knee, plain code above
  assign wid_len = (int'(cfg.wid) < WID_KNEE) ? WD_W'(WID_BASE) + WD_W'(cfg.wid)
                                              : WD_W'(cfg.wid);

  tdw_stretch #(.CNT_W(WD_W)) u_wid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rise),
    .len_i   (wid_len),
    .out_o   (lvl1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_o     <= '0;
      mult_vld_o <= 1'b0;
    end else begin
      mult_vld_o <= samp_fire;
      if (samp_fire) mult_o <= mult_i;
    end
  end

  p_cfg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q == $past(cfg_wdata_i));
  p_vld_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_vld_o == samp_stb_o);
  p_mult_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mult_vld_o |-> $stable(mult_o));
  p_lvl1_on_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> lvl1_o);
  p_mdc_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && cfg.mdc_out == '0) |=> mdc_out_o);
endmodule

// File: tb/sim_tdw_gen.sv
module sim_tdw_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        trig_i = 1'b0;
  logic [23:0] mult_i = '0;
  logic        samp_stb_o, mult_vld_o, mdc_in_o, mdc_out_o, lvl1_o;
  logic [23:0] mult_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  tdw_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .trig_i(trig_i), .mult_i(mult_i), .samp_stb_o(samp_stb_o), .mult_o(mult_o),
    .mult_vld_o(mult_vld_o), .mdc_in_o(mdc_in_o), .mdc_out_o(mdc_out_o), .lvl1_o(lvl1_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int k);
    return 24'((k + 2) * 977 + 13);
  endfunction

  function automatic logic [31:0] mkw(input int s, input int o, input int i, input int w);
    return (32'(w & 15) << 28) | (32'(i & 31) << 17) | (32'(o & 31) << 12) | 32'(s & 15);
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = w;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // one trigger; expectations from word w; retrig=1 also toggles trig and writes w2 mid-run
  task automatic run(input logic [31:0] w, input bit retrig, input logic [31:0] w2, input string tg);
    int sc = int'(w[3:0]);
    int oc = int'(w[16:12]);
    int ic = int'(w[21:17]);
    int wc = int'(w[31:28]);
    int exp_s = 6 + sc;
    int exp_o = 4 * oc;
    int exp_i = 4 * ic;
    int exp_w = (wc < 7) ? 21 + wc : wc;
    int fs = -1, ns = 0, fo = -1, no = 0, fi = -1, ni = 0, fl = -1, nl = 0, vbad = 0;
    logic [23:0] got = '0;
    @(negedge clk_i);
    trig_i = 1'b1;
    mult_i = pat(-1);
    for (int k = 0; k < 160; k++) begin
      @(negedge clk_i);
      if (samp_stb_o) begin ns++; if (fs < 0) fs = k; got = mult_o; end
      if (mult_vld_o != samp_stb_o) vbad++;
      if (mdc_out_o) begin no++; if (fo < 0) fo = k; end
      if (mdc_in_o)  begin ni++; if (fi < 0) fi = k; end
      if (lvl1_o)    begin nl++; if (fl < 0) fl = k; end
      mult_i = pat(k);
      if (retrig) begin
        if (k == 2) begin cfg_we_i = 1'b1; cfg_wdata_i = w2; end
        if (k == 3) begin cfg_we_i = 1'b0; trig_i = 1'b0; end
        if (k == 5) trig_i = 1'b1;
      end
    end
    trig_i = 1'b0;
    chk(fs == exp_s, retrig ? "R9" : "R2", {tg, " samp position"}, fs, exp_s);
    chk(ns == 1, retrig ? "R8" : "R7", {tg, " samp count"}, ns, 1);
    chk(vbad == 0, "R3", {tg, " vld/stb mismatch cycles"}, vbad, 0);
    chk(got == pat(exp_s - 1), "R3", {tg, " mult value"}, got, pat(exp_s - 1));
    chk(fo == exp_o, retrig ? "R9" : "R4", {tg, " outer position"}, fo, exp_o);
    chk(no == 1, retrig ? "R8" : "R7", {tg, " outer count"}, no, 1);
    chk(fi == exp_i, retrig ? "R9" : "R5", {tg, " inner position"}, fi, exp_i);
    chk(ni == 1, retrig ? "R8" : "R7", {tg, " inner count"}, ni, 1);
    chk(fl == 0, "R6", {tg, " lvl1 start"}, fl, 0);
    chk(nl == exp_w, retrig ? "R9" : "R6", {tg, " lvl1 width"}, nl, exp_w);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({samp_stb_o, mult_vld_o, mdc_in_o, mdc_out_o, lvl1_o} == 5'b0, "R10",
        "outputs in reset", {samp_stb_o, mult_vld_o, mdc_in_o, mdc_out_o, lvl1_o}, 0);
    chk(mult_o == '0, "R10", "mult_o in reset", mult_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run(32'h0, 1'b0, 32'h0, "R10 reset word");
    // sweep every sampling and width code, scattered delay codes
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w = mkw(i, (i * 3) % 32, (i * 7 + 5) % 32, i);
      write_cfg(w);
      run(w, 1'b0, 32'h0, "R1 sweep");
    end
    write_cfg(mkw(15, 31, 0, 7));
    run(mkw(15, 31, 0, 7), 1'b0, 32'h0, "R4 max outer");
    write_cfg(mkw(0, 0, 31, 6));
    run(mkw(0, 0, 31, 6), 1'b0, 32'h0, "R5 max inner");
    // retrigger and mid-run write, then the new word on the next trigger
    write_cfg(mkw(9, 20, 3, 4));
    run(mkw(9, 20, 3, 4), 1'b1, mkw(2, 1, 12, 10), "R8 busy");
    run(mkw(2, 1, 12, 10), 1'b0, 32'h0, "R1 next trigger");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule